// File: doc/BRIEF.md
# Serial ADC host controller

This block runs a 12-bit serial converter that has a single conversion-start strobe and a full-duplex shift port. A start request, together with a 2-bit channel/mode word, raises the strobe. The strobe then stays high for a fixed number of system clocks while the converter samples and converts. When the strobe falls, the controller generates exactly twelve serial clock pulses. During these pulses it shifts the channel/mode word out on the serial data output and collects the result bits, most significant first, from the serial data input.

The converter uses the channel/mode word it receives in a frame for its following conversion. The controller therefore tags each returned result with the word it sent one frame earlier. If the sleep-hold input is high when the conversion time ends, the controller keeps the strobe high, which lets the converter sleep. A later start request wakes it, and the data frame then begins with the newly supplied word.

Top module: `adcHost`

## Requirements
- R1: While reset is asserted (rstN low), convStrobe, sck, sdi, busy and resultValid are all 0.
- R2: A start request accepted while idle raises convStrobe on the next clock. convStrobe then stays high for exactly CONV_CYCLES clocks and falls, unless the sleep-hold case of R9 applies.
- R3: After convStrobe falls, sck makes exactly RES_BITS (12) pulses. Each pulse is low for HALF_CYCLES clocks and then high for HALF_CYCLES clocks. sck is low at all other times, including whenever convStrobe is high.
- R4: sdi carries cfgIn[1] from the strobe's falling edge until the first sck fall, and cfgIn[0] until the second sck fall. It is 0 after that and between frames. sdi changes only when sck or convStrobe falls.
- R5: On each clock edge where sck rises, sdo is sampled. The 12 samples form result with the first sample in bit 11 and the last in bit 0.
- R6: resultCfg is the channel/mode word sent in the frame before the one that returned result. For the first frame after reset it is 2'b00.
- R7: resultValid is high for exactly one clock, on the clock where the final sck fall takes place. result and resultCfg hold their values until the next resultValid.
- R8: busy is high from the clock after an accepted start until resultValid. It is not high in the sleep-hold state. A start request while busy is high has no effect on convStrobe, sck, sdi or the word that is sent.
- R9: If sleepHold is high on the last conversion clock, convStrobe stays high and busy goes low until a start request arrives. On that request, cfgIn is taken as the word for the frame, convStrobe falls on the next clock, and the frame of R3 to R5 follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, or wake request in sleep-hold |
| cfgIn | input | 2 | Channel/mode word for the next conversion |
| sleepHold | input | 1 | Keep the strobe high after conversion |
| sdo | input | 1 | Serial result data from the converter |
| convStrobe | output | 1 | Conversion start and frame select |
| sck | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial channel/mode data to the converter |
| busy | output | 1 | Conversion or transfer in progress |
| resultValid | output | 1 | One-clock pulse when result is updated |
| result | output | 12 | Last captured conversion result |
| resultCfg | output | 2 | Channel/mode word that result belongs to |

## Verification
The hardest situation to reach is a wake from sleep-hold with a word different from the one that started the conversion. In that case the tag sequence must follow the word given at wake time. The stimulus reaches it by holding sleepHold through a conversion and leaving the strobe high for several idle clocks. It then wakes the controller with a new word, and a bench-side converter model checks the next frame's tag. The same sequence also fires a start request in the middle of a conversion, so that an ignored request shows up as an unchanged sent word. A further start request is issued in the very clock of resultValid, which exercises back-to-back frames.

// File: rtl/adcHostPkg.sv
package adcHostPkg;
  typedef struct packed {
    logic loadCfg;     // accept a new channel/mode word
    logic beginFrame;  // strobe falls, first data bit goes out
    logic sampleEdge;  // sck rises, capture sdo
    logic launchEdge;  // sck falls within the frame, next sdi bit
    logic finish;      // final sck fall, publish result
  } ctlStrobes_t;
endpackage

// File: rtl/adcHostCtrl.sv
module adcHostCtrl
  import adcHostPkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int HALF_CYCLES = 2,
  parameter int RES_BITS    = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        sleepHold,
  output logic        convStrobe,
  output logic        sck,
  output logic        busy,
  output ctlStrobes_t strobes
);
  localparam int MAX_CNT = (CONV_CYCLES > HALF_CYCLES) ? CONV_CYCLES : HALF_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int BIT_W   = $clog2(RES_BITS + 1);

  typedef enum logic [1:0] {IDLE, CONV, SLEEP, SHIFT} ctlState_t;

  ctlState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic            sckR, strobeR;
  logic            convDone, halfDone;

  assign convDone = (state == CONV) && (cnt == CNT_W'(CONV_CYCLES - 1));
  assign halfDone = (state == SHIFT) && (cnt == CNT_W'(HALF_CYCLES - 1));

  always_comb begin
    strobes.loadCfg    = startReq && ((state == IDLE) || (state == SLEEP));
    strobes.beginFrame = (convDone && !sleepHold) || ((state == SLEEP) && startReq);
    strobes.sampleEdge = halfDone && !sckR;
    strobes.finish     = halfDone && sckR && (bitCnt == BIT_W'(RES_BITS));
    strobes.launchEdge = halfDone && sckR && (bitCnt != BIT_W'(RES_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      cnt     <= '0;
      bitCnt  <= '0;
      sckR    <= 1'b0;
      strobeR <= 1'b0;
    end else begin
      if (strobes.beginFrame) begin
        state   <= SHIFT;
        strobeR <= 1'b0;
        cnt     <= '0;
        bitCnt  <= '0;
      end else begin
        case (state)
          IDLE: if (startReq) begin
            strobeR <= 1'b1;
            cnt     <= '0;
            state   <= CONV;
          end
          CONV: begin
            cnt <= cnt + 1'b1;
            if (convDone) state <= SLEEP;
          end
          SLEEP: ;
          SHIFT: begin
            if (halfDone) begin
              cnt <= '0;
              if (!sckR) begin
                sckR   <= 1'b1;
                bitCnt <= bitCnt + 1'b1;
              end else begin
                sckR <= 1'b0;
                if (bitCnt == BIT_W'(RES_BITS)) state <= IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assign convStrobe = strobeR;
  assign sck        = sckR;
  assign busy       = (state == CONV) || (state == SHIFT);
endmodule

// File: rtl/adcHostData.sv
module adcHostData
  import adcHostPkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CFG_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [CFG_BITS-1:0] cfgIn,
  input  logic                sdo,
  output logic                sdi,
  output logic [RES_BITS-1:0] result,
  output logic [CFG_BITS-1:0] resultCfg,
  output logic                resultValid
);
  logic [CFG_BITS-1:0] curCfg, prevCfg, txReg, frameCfg;
  logic [RES_BITS-1:0] rxReg;

  assign frameCfg = strobes.loadCfg ? cfgIn : curCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCfg      <= '0;
      prevCfg     <= '0;
      txReg       <= '0;
      rxReg       <= '0;
      sdi         <= 1'b0;
      result      <= '0;
      resultCfg   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobes.finish;
      if (strobes.loadCfg) curCfg <= cfgIn;
      if (strobes.beginFrame) begin
        sdi   <= frameCfg[CFG_BITS-1];
        txReg <= frameCfg << 1;
      end
      if (strobes.launchEdge) begin
        sdi   <= txReg[CFG_BITS-1];
        txReg <= txReg << 1;
      end
      if (strobes.sampleEdge) rxReg <= {rxReg[RES_BITS-2:0], sdo};
      if (strobes.finish) begin
        sdi       <= 1'b0;
        result    <= rxReg;
        resultCfg <= prevCfg;
        prevCfg   <= curCfg;
      end
    end
  end
endmodule

// File: rtl/adcHost.sv
module adcHost
  import adcHostPkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int HALF_CYCLES = 2,
  parameter int RES_BITS    = 12,
  parameter int CFG_BITS    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [CFG_BITS-1:0] cfgIn,
  input  logic                sleepHold,
  input  logic                sdo,
  output logic                convStrobe,
  output logic                sck,
  output logic                sdi,
  output logic                busy,
  output logic                resultValid,
  output logic [RES_BITS-1:0] result,
  output logic [CFG_BITS-1:0] resultCfg
);
  ctlStrobes_t strobes;

  adcHostCtrl #(.CONV_CYCLES(CONV_CYCLES), .HALF_CYCLES(HALF_CYCLES), .RES_BITS(RES_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sleepHold(sleepHold),
    .convStrobe(convStrobe), .sck(sck), .busy(busy), .strobes(strobes)
  );

  adcHostData #(.RES_BITS(RES_BITS), .CFG_BITS(CFG_BITS)) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgIn(cfgIn), .sdo(sdo),
    .sdi(sdi), .result(result), .resultCfg(resultCfg), .resultValid(resultValid)
  );
endmodule

// File: rtl/adcHostChk.sv
module adcHostChk #(
  parameter int RES_BITS = 12,
  parameter int CFG_BITS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic                convStrobe,
  input logic                sck,
  input logic                sdi,
  input logic                busy,
  input logic                resultValid,
  input logic [RES_BITS-1:0] result,
  input logic [CFG_BITS-1:0] resultCfg
);
  // R3
  sck_quiet_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |-> !sck);
  // R2
  strobe_rise_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStrobe) |-> $past(startReq));
  // R4
  sdi_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdi) |-> ($fell(sck) || $fell(convStrobe)));
  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(result) && $stable(resultCfg)));
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (resultValid || convStrobe));
  // R8
  valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy);
endmodule

bind adcHost adcHostChk #(.RES_BITS(RES_BITS), .CFG_BITS(CFG_BITS)) chk (.*);

// File: tb/adcHost_test.sv
module adcHost_test;
  localparam int CONV = 20;
  localparam int HALF = 2;

  logic clk = 0, rstN = 0, startReq = 0, sleepHold = 0, sdo = 0;
  logic [1:0] cfgIn = 0;
  logic convStrobe, sck, sdi, busy, resultValid;
  logic [11:0] result;
  logic [1:0] resultCfg;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adcHost #(.CONV_CYCLES(CONV), .HALF_CYCLES(HALF)) uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // converter model
  int emuBit = 0, rxCount = 0, riseCount = 0, emuFrame = 0;
  logic [1:0] rxBits = 0, convCfg = 0, pendingCfg = 0;
  logic [11:0] emuWord = 0;
  always @(posedge convStrobe) convCfg = pendingCfg;
  always @(negedge convStrobe) if (rstN) begin
    emuWord  = {convCfg, 10'(emuFrame * 37 + 5)};
    emuFrame++;
    emuBit   = 11;
    sdo      = emuWord[11];
    rxCount  = 0;
    riseCount = 0;
  end
  always @(posedge sck) if (!convStrobe) begin
    if (rxCount < 2) rxBits = {rxBits[0], sdi};
    rxCount++;
    riseCount++;
    if (rxCount == 2) pendingCfg = rxBits;
  end
  always @(negedge sck) begin
    if (emuBit > 0) begin emuBit--; sdo = emuWord[emuBit]; end
    else sdo = 0;
  end

  // cycle reference model
  int mode = 0, cnt = 0, pulses = 0;
  logic [1:0] cfgCur = 0, lastSent = 0, expTag = 0, expSent = 0;
  logic eStrobe = 0, eSck = 0, eSdi = 0, eValid = 0;

  task automatic beginFrame();
    mode = 3; cnt = 0; pulses = 0; eSck = 0; eStrobe = 0; eSdi = cfgCur[1];
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mode = 0; cnt = 0; pulses = 0; cfgCur = 0; lastSent = 0;
      eStrobe = 0; eSck = 0; eSdi = 0; eValid = 0;
    end else begin
      eValid = 0;
      case (mode)
        0: if (startReq) begin cfgCur = cfgIn; eStrobe = 1; cnt = 0; mode = 1; end
        1: begin
          cnt++;
          if (cnt == CONV) begin
            if (sleepHold) mode = 2; else beginFrame();
          end
        end
        2: if (startReq) begin cfgCur = cfgIn; beginFrame(); end
        default: begin
          cnt++;
          if (cnt == HALF) begin
            cnt = 0;
            if (!eSck) begin eSck = 1; pulses++; end
            else begin
              eSck = 0;
              if (pulses == 12) begin
                eValid = 1; mode = 0; eSdi = 0;
                expTag = lastSent; expSent = cfgCur; lastSent = cfgCur;
              end else eSdi = (pulses == 1) ? cfgCur[0] : 1'b0;
            end
          end
        end
      endcase
    end
  end

  always @(negedge clk) if (rstN && !finished) begin
    chk("R2/R9", "convStrobe", convStrobe, eStrobe);
    chk("R3", "sck", sck, eSck);
    chk("R4", "sdi", sdi, eSdi);
    chk("R8", "busy", busy, (mode == 1 || mode == 3));
    chk("R7", "resultValid", resultValid, eValid);
    if (eValid) begin
      chk("R5", "result", result, emuWord);
      chk("R6", "resultCfg", resultCfg, expTag);
      chk("R6", "tag vs converter", resultCfg, result[11:10]);
      chk("R4", "word received", rxBits, expSent);
      chk("R3", "sck pulses", riseCount, 12);
    end
  end

  task automatic runFrame(logic [1:0] cfg, bit hold, logic [1:0] wakeCfg, bit intrude);
    startReq = 1; cfgIn = cfg; sleepHold = hold;
    @(negedge clk);
    startReq = 0;
    if (intrude) begin
      repeat (5) @(negedge clk);
      startReq = 1; cfgIn = ~cfg;    // R8: ignored while busy
      @(negedge clk);
      startReq = 0;
    end
    if (hold) begin
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R9", "strobe held in sleep", convStrobe, 1);
      chk("R9", "busy low in sleep", busy, 0);
      startReq = 1; cfgIn = wakeCfg;
      @(negedge clk);
      startReq = 0; sleepHold = 0;
    end
    while (!resultValid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "convStrobe", convStrobe, 0);
    chk("R1", "sck", sck, 0);
    chk("R1", "sdi", sdi, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "resultValid", resultValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    runFrame(2'b10, 0, 2'b00, 0);
    repeat (3) @(negedge clk);
    runFrame(2'b01, 0, 2'b00, 1);
    repeat (4) @(negedge clk);
    runFrame(2'b11, 1, 2'b00, 0);
    repeat (2) @(negedge clk);
    runFrame(2'b01, 0, 2'b00, 0);
    runFrame(2'b10, 0, 2'b00, 0);   // issued in the valid clock
    runFrame(2'b11, 0, 2'b00, 0);
    repeat (6) @(negedge clk);
    chk("R3", "sck idle", sck, 0);
    chk("R7", "result held", result, emuWord);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule